// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable model of a single-port synchronous SRAM with pipelined reads and four-word bursts. Each data word is split into byte lanes of nine bits (four lanes by default). The depth comes from the address-width parameter. Address, write data, chip enables, write controls and burst controls are all registered on the rising clock edge.

A cycle starts from one of two address strobes. The processor strobe only counts when the first chip enable is low, and it always starts a read. The controller strobe always counts. It selects or deselects the device from the three chip enables, and it starts a read or a write depending on the write controls. While a burst runs, the two low address bits come from an internal step counter. The counter moves in linear or interleaved order when the advance input is low and holds when it is high. Writes can cover the whole word through a global write input, or single lanes through a byte-write enable and per-lane enables. An output enable gates the read-valid flag without a clock. A sleep input makes the device ignore all cycles.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `rvalid` is low and no burst is active, so a lone advance pulse produces no read.
- R2: When `strobe_p_n`=0, `ce0_n`=0 and the device is selected (`ce0_n`=0, `ce1`=1, `ce2_n`=0), the block reads the word at `addr`. The word appears on `rdata` with `rvalid`=1 in the clock cycle after that edge. A processor-strobe cycle is always a read, even when the write controls request a write.
- R3: A processor strobe with `ce0_n`=1, while `strobe_c_n` is high, starts no cycle, and neither a read nor a write takes place.
- R4: When `strobe_c_n`=0 and the device is selected, the cycle is a write if `gw_n`=0, or if `bwe_n`=0 with at least one `bw_n` bit low. Otherwise the cycle is a read. Write data is taken on the same edge.
- R5: An address strobe that meets a chip-enable set which does not select the device deselects it. No read or write takes place, and the burst ends, so later advance pulses do nothing.
- R6: With `order_sel`=0 at burst start, the low address bits go base, base+1, base+2, base+3 (modulo 4) and then wrap again. The upper address bits stay fixed.
- R7: With `order_sel`=1 at burst start, the low address bits are base XOR step (step 0,1,2,3,...). The order is captured at burst start, so `order_sel` changes during the burst have no effect.
- R8: When both strobes and `adv_n` are high, the cycle is a wait cycle. The address does not move, nothing is written, `rvalid` is low in the next cycle, and `rdata` holds its value.
- R9: When both strobes are high and `adv_n`=0, the burst continues at the next address and keeps the read or write type of the cycle that started it. Continuation write data is taken on that same edge.
- R10: When `gw_n`=0 in a write, all 36 bits are written, whatever `bwe_n` and `bw_n` are.
- R11: When `gw_n`=1, lane i (bits 9i+8..9i) is written only when `bwe_n`=0 and `bw_n[i]`=0. With `bwe_n`=1 the lane enables have no effect.
- R12: `oe_n`=1 forces `rvalid` low at once, without a clock. The last read word stays on `rdata` and shows as valid again as soon as `oe_n` returns low.
- R13: While `sleep`=1, strobes and advance are ignored, memory is unchanged, any running burst ends, and `rvalid` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| ce0_n | input | 1 | Active-low chip enable; also gates the processor strobe |
| ce1 | input | 1 | Active-high chip enable |
| ce2_n | input | 1 | Active-low chip enable |
| strobe_p_n | input | 1 | Processor address strobe, active low, read only |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Active-low burst advance; high gives a wait cycle |
| gw_n | input | 1 | Active-low global (full-word) write |
| bwe_n | input | 1 | Active-low byte-write enable |
| bw_n | input | LANES | Active-low per-lane write enables |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Active-high standby |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W | Read data |
| rvalid | output | 1 | Read data valid, gated by oe_n |

## Verification
A read started or advanced at a clock edge is due on `rdata`/`rvalid` in the cycle right after that edge. Writes, waits, deselects and sleep cycles are due there as `rvalid` low. Each cycle the driver queues the expected result, and a monitor pops it 5 ns after the next rising edge. Stored words are checked by later reads, whose results are due one cycle after their own edge. The output-enable gating is combinational, so it is checked within a nanosecond of toggling `oe_n`, with no clock edge in between.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int LANE_W_DEF = 9;
    localparam int LANES_DEF  = 4;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sbs_op_e;
endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq (
    input  logic [1:0] base,
    input  logic [1:0] step,
    input  logic       interleave,
    output logic [1:0] offset
);
    always_comb begin
        if (interleave) offset = base ^ step;
        else            offset = base + step;
    end
endmodule

// File: rtl/sbs_lane_decode.sv
module sbs_lane_decode #(
    parameter int LANES = sbs_pkg::LANES_DEF
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // a global write overrides the byte-write path
        assign lane_we[i] = !gw_n || (!bwe_n && !bw_n[i]);
    end
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = sbs_pkg::LANES_DEF,
    parameter int LANE_W = sbs_pkg::LANE_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        we,
    input  logic                    re,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  rd_q <= '0;
            else if (re) rd_q <= mem[addr];
        end

        assign rdata[i*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = sbs_pkg::LANES_DEF,
    parameter int LANE_W = sbs_pkg::LANE_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    ce0_n,
    input  logic                    ce1,
    input  logic                    ce2_n,
    input  logic                    strobe_p_n,
    input  logic                    strobe_c_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    order_sel,
    input  logic                    sleep,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    import sbs_pkg::*;

    localparam int UP_W = ADDR_W - 2;

    typedef struct packed {
        logic            active;
        logic            wr_burst;
        logic            interleave;
        logic [1:0]      base;
        logic [1:0]      step;
        logic [UP_W-1:0] upper;
        logic            rd_pend;
    } ctl_t;

    ctl_t        ctl_d, ctl_q;
    sbs_op_e     op;
    logic        selected, p_go, c_go;
    logic [LANES-1:0] lane_we, arr_we;
    logic [1:0]  offset;

    sbs_lane_decode #(.LANES(LANES)) u_dec (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (lane_we)
    );

    always_comb begin
        selected = !ce0_n && ce1 && !ce2_n;
        p_go     = !strobe_p_n && !ce0_n;
        c_go     = !strobe_c_n;
        ctl_d         = ctl_q;
        ctl_d.rd_pend = 1'b0;
        op            = OP_NONE;
        if (sleep) begin
            ctl_d.active = 1'b0;
        end else if (p_go || c_go) begin
            if (selected) begin
                ctl_d.active     = 1'b1;
                ctl_d.wr_burst   = !p_go && (|lane_we);
                ctl_d.interleave = order_sel;
                ctl_d.base       = addr[1:0];
                ctl_d.step       = 2'd0;
                ctl_d.upper      = addr[ADDR_W-1:2];
                op = ctl_d.wr_burst ? OP_WRITE : OP_READ;
            end else begin
                ctl_d.active = 1'b0;
            end
        end else if (ctl_q.active && !adv_n && strobe_p_n && strobe_c_n) begin
            ctl_d.step = ctl_q.step + 2'd1;
            op = ctl_q.wr_burst ? OP_WRITE : OP_READ;
        end
        ctl_d.rd_pend = (op == OP_READ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    sbs_burst_seq u_seq (
        .base       (ctl_d.base),
        .step       (ctl_d.step),
        .interleave (ctl_d.interleave),
        .offset     (offset)
    );

    assign arr_we = (op == OP_WRITE) ? lane_we : '0;

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .re    (op == OP_READ),
        .addr  ({ctl_d.upper, offset}),
        .wdata (wdata),
        .rdata (rdata)
    );

    assign rvalid = ctl_q.rd_pend && !oe_n;
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              strobe_p_n,
    input logic              strobe_c_n,
    input logic              ce0_n,
    input logic              ce1,
    input logic              ce2_n,
    input logic              adv_n,
    input logic              gw_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid
);
    logic sel;
    assign sel = !ce0_n && ce1 && !ce2_n;

    // R13
    sleep_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rvalid);

    // R8
    wait_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && strobe_p_n && strobe_c_n && adv_n) |=> !rvalid);

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && strobe_p_n && strobe_c_n && adv_n) |=> $stable(rdata));

    // R5
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strobe_c_n && !sel) |=> !rvalid);

    // R2
    proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strobe_p_n && sel) |=> (rvalid || oe_n));

    // R3
    proc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strobe_p_n && ce0_n && strobe_c_n) |=> !rvalid);

    // R4
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && strobe_p_n && !strobe_c_n && sel && !gw_n) |=> !rvalid);
endmodule

bind sync_burst_sram sbs_checker #(.DATA_W(LANES*LANE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .ce0_n      (ce0_n),
    .ce1        (ce1),
    .ce2_n      (ce2_n),
    .adv_n      (adv_n),
    .gw_n       (gw_n),
    .oe_n       (oe_n),
    .rdata      (rdata),
    .rvalid     (rvalid)
);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [35:0] wdata = '0;
    logic        ce0_n, ce1, ce2_n, strobe_p_n, strobe_c_n, adv_n;
    logic        gw_n, bwe_n, sleep, oe_n;
    logic [3:0]  bw_n;
    logic        order_sel = 1'b0;
    logic [35:0] rdata;
    logic        rvalid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [35:0] ref_m [256];

    logic        q_chk [$];
    logic        q_val [$];
    logic [35:0] q_dat [$];
    string       q_tag [$];

    always #10 clk = ~clk;

    sync_burst_sram uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
        .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .order_sel(order_sel),
        .sleep(sleep), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic idle();
        strobe_p_n = 1; strobe_c_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; bw_n = 4'hF;
        ce0_n = 0; ce1 = 1; ce2_n = 0;
        sleep = 0; oe_n = 0;
    endtask

    task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: queue the result due one cycle after this edge, then advance
    task automatic tick(input logic chk, input logic ev, input logic [35:0] ed, input string tag);
        q_chk.push_back(chk); q_val.push_back(ev); q_dat.push_back(ed); q_tag.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    // monitor
    always @(posedge clk) begin
        #5;
        if (q_chk.size() > 0) begin
            logic c, v;
            logic [35:0] d;
            string t;
            c = q_chk.pop_front(); v = q_val.pop_front();
            d = q_dat.pop_front(); t = q_tag.pop_front();
            if (c) begin
                checks++;
                if (rvalid !== v || (v && rdata !== d)) begin
                    failures++;
                    $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h", t, rvalid, rdata, v, d);
                end
            end
        end
    end

    task automatic wr_start(input logic [7:0] a, input logic [35:0] d, input string tag);
        strobe_c_n = 0; addr = a; wdata = d; gw_n = 0;
        ref_m[a] = d;
        tick(1, 0, '0, tag);
    endtask

    task automatic wr_next(input logic [7:0] a, input logic [35:0] d, input string tag);
        adv_n = 0; gw_n = 0; wdata = d;
        ref_m[a] = d;
        tick(1, 0, '0, tag);
    endtask

    task automatic rd_start(input logic [7:0] a, input string tag);
        strobe_p_n = 0; addr = a;
        tick(1, 1, ref_m[a], tag);
    endtask

    task automatic rd_next(input logic [7:0] a, input string tag);
        adv_n = 0;
        tick(1, 1, ref_m[a], tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(rvalid === 1'b0, "R1 reset rvalid", {35'd0, rvalid}, '0);
        adv_n = 0; tick(1, 0, '0, "R1 advance after reset");

        // R9 R10 linear write burst 0x10..0x13
        order_sel = 0;
        wr_start(8'h10, 36'h5_1111_0000, "R4 write start");
        wr_next(8'h11, 36'h5_1111_0001, "R9 write cont");
        wr_next(8'h12, 36'h5_1111_0002, "R9 write cont");
        wr_next(8'h13, 36'h5_1111_0003, "R9 write cont");

        // R2 R6 linear read from base 1, two wraps
        rd_start(8'h11, "R2 proc read");
        rd_next(8'h12, "R6 linear");
        rd_next(8'h13, "R6 linear");
        rd_next(8'h10, "R6 linear wrap");
        rd_next(8'h11, "R6 linear wrap again");

        // R7 interleaved from base 1, order captured
        order_sel = 1;
        rd_start(8'h11, "R7 interleaved start");
        order_sel = 0;
        rd_next(8'h10, "R7 interleaved");
        rd_next(8'h13, "R7 interleaved");
        rd_next(8'h12, "R7 interleaved");

        // R8 wait cycles in a read burst
        rd_start(8'h12, "R8 start");
        tick(1, 0, '0, "R8 wait");
        rd_next(8'h13, "R8 after wait");
        tick(1, 0, '0, "R8 wait");
        rd_next(8'h10, "R8 after wait");

        // R5 deselect via controller strobe
        strobe_c_n = 0; ce1 = 0; addr = 8'h10; tick(1, 0, '0, "R5 deselect ce1");
        adv_n = 0; tick(1, 0, '0, "R5 burst ended");
        strobe_p_n = 0; ce2_n = 1; addr = 8'h11; tick(1, 0, '0, "R5 deselect ce2_n");
        adv_n = 0; tick(1, 0, '0, "R5 burst ended");

        // R3 gated processor strobe
        strobe_p_n = 0; ce0_n = 1; addr = 8'h10; tick(1, 0, '0, "R3 gated strobe");
        adv_n = 0; tick(1, 0, '0, "R3 no burst");

        // R2 processor strobe ignores write controls
        strobe_p_n = 0; gw_n = 0; addr = 8'h12; wdata = 36'h0_DEAD_BEEF;
        tick(1, 1, ref_m[8'h12], "R2 proc with gw");
        rd_start(8'h12, "R2 word unchanged");

        // R11 byte-lane write
        wr_start(8'h20, 36'h1_2345_6789, "R4 write");
        strobe_c_n = 0; addr = 8'h20; bwe_n = 0; bw_n = 4'b1010; wdata = 36'hF_FFFF_FFFF;
        for (int i = 0; i < 4; i++)
            if (!bw_n[i]) ref_m[8'h20][i*9 +: 9] = wdata[i*9 +: 9];
        tick(1, 0, '0, "R11 byte write");
        rd_start(8'h20, "R11 lanes 0 and 2");
        // R4 R11 lane enables without bwe_n -> read
        strobe_c_n = 0; addr = 8'h20; bwe_n = 1; bw_n = 4'h0; wdata = '0;
        tick(1, 1, ref_m[8'h20], "R11 bwe_n high reads");

        // R10 global write override
        strobe_c_n = 0; addr = 8'h21; gw_n = 0; bwe_n = 1; bw_n = 4'hF; wdata = 36'h9_8765_4321;
        ref_m[8'h21] = wdata; tick(1, 0, '0, "R10 gw full");
        strobe_c_n = 0; addr = 8'h22; gw_n = 0; bwe_n = 0; bw_n = 4'b1110; wdata = 36'h3_CAFE_0042;
        ref_m[8'h22] = wdata; tick(1, 0, '0, "R10 gw over lanes");
        rd_start(8'h21, "R10 read back");
        rd_start(8'h22, "R10 read back");

        // R12 asynchronous output enable
        strobe_p_n = 0; addr = 8'h21; oe_n = 1;
        q_chk.push_back(1); q_val.push_back(0); q_dat.push_back('0); q_tag.push_back("R12 oe high");
        @(posedge clk); @(negedge clk);
        oe_n = 0; #1;
        check(rvalid === 1'b1 && rdata === ref_m[8'h21], "R12 oe low async", rdata, ref_m[8'h21]);
        oe_n = 1; #1;
        check(rvalid === 1'b0, "R12 oe high async", {35'd0, rvalid}, '0);
        idle();

        // R13 sleep ignores writes and ends bursts
        strobe_c_n = 0; addr = 8'h21; gw_n = 0; wdata = '0; sleep = 1;
        tick(1, 0, '0, "R13 sleep write");
        rd_start(8'h21, "R13 memory unchanged");
        rd_start(8'h10, "R13 start");
        adv_n = 0; sleep = 1; tick(1, 0, '0, "R13 sleep advance");
        adv_n = 0; tick(1, 0, '0, "R13 burst ended");

        // R8 wait inside a write burst
        wr_start(8'h30, 36'h7_0000_0030, "R4 write");
        gw_n = 0; wdata = 36'h0_BAD0_0BAD; tick(1, 0, '0, "R8 write wait");
        wr_next(8'h31, 36'h7_0000_0031, "R9 write after wait");
        rd_start(8'h30, "R8 no write in wait");
        rd_next(8'h31, "R9 cont write landed");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule